// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit serves one access path (instruction fetch or data) of a processor's memory management. It keeps a small table built from upper/lower register pairs. Each pair describes one naturally aligned block of effective address space and the real block it maps to. A synchronize strobe rebuilds the table from the raw register pairs and the current privilege mode. After that, every effective address presented with an access type is compared against all active entries in the same cycle.

A matching block returns the real address, the block's protection code and either a hit or a protection fault. With no match, both flags stay low so that a downstream page translator can take the access. Bit positions below use LSB-0 numbering of 64-bit registers. Upper pair register: block effective index in [63:17], block length in [12:2], supervisor-valid in [1], user-valid in [0]. Lower pair register: block real page in [63:17], protection code in [1:0].

Top module: `bat_block_matcher`

## Requirements
- R1: After reset the table is empty, so every lookup reports `hit_o`=0, `fault_o`=0, `real_addr_o`=0 and `prot_o`=0.
- R2: A table rebuild requested by `sync_i` takes effect on the cycle after the strobe. Lookups during the strobe cycle use the previous table.
- R3: At a rebuild, a pair is active only if its user-valid bit (upper[0]) is set when `problem_i`=1, or its supervisor-valid bit (upper[1]) is set when `problem_i`=0. The mode captured at the rebuild is the mode used for protection.
- R4: A pair's offset mask is the 11-bit length field upper[12:2] placed at bits [27:17], with bits [16:0] all ones. The smallest block is therefore 128 KB. An active pair matches when the effective address equals upper[63:17] (low bits zero) at every bit outside the mask.
- R5: On a match, `real_addr_o` is lower[63:17] (low 17 bits zero) ORed with the effective address ANDed with the offset mask.
- R6: When several active pairs match, the pair with the lowest index wins.
- R7: On a match, `prot_o` carries the winning pair's lower[1:0].
- R8: Access type `acc_i` is 00 instruction fetch, 01 data read, 10 data write (11 acts as a read). A write to a block with protection 01 or 11 (read-only) raises `fault_o` instead of `hit_o`. Protection 10 allows every access.
- R9: Protection 00 faults every access when the captured mode is problem state, and allows every access in supervisor state.
- R10: With no match, `hit_o`, `fault_o`, `real_addr_o` and `prot_o` are all zero. `hit_o` and `fault_o` are never both high.
- R11: Changes to the raw register pairs or to `problem_i` without a strobe have no effect on lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Context synchronize strobe, rebuilds the table |
| problem_i | input | 1 | Privilege mode, 1 = problem (user) state |
| upper_i | input | 64*PAIRS | Raw upper registers, pair i at [i*64 +: 64] |
| lower_i | input | 64*PAIRS | Raw lower registers, pair i at [i*64 +: 64] |
| ea_i | input | 64 | Effective address to translate |
| acc_i | input | 2 | Access type |
| hit_o | output | 1 | Active block matched and access permitted |
| fault_o | output | 1 | Active block matched but access denied |
| real_addr_o | output | 64 | Translated real address |
| prot_o | output | 2 | Protection code of the winning block |

## Verification
A corrupted stored entry shows at the ports in the first lookup that touches its block. The symptoms are a miss where a hit is due, a wrong real address in the offset or page bits, or a wrong protection code. Because the lookup is combinational on the stored table, any such error is visible in the same cycle the address is presented. A stale or early rebuild shows as the wrong table being used in the strobe cycle or the one after it. A wrong captured mode shows as wrongly active entries and as a protection-00 outcome that disagrees with the mode.

// File: rtl/bat_block_matcher.sv
module bat_block_matcher #(
  parameter int PAIRS = 4
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                sync_i,
  input  logic                problem_i,
  input  logic [PAIRS*64-1:0] upper_i,
  input  logic [PAIRS*64-1:0] lower_i,
  input  logic [63:0]         ea_i,
  input  logic [1:0]          acc_i,
  output logic                hit_o,
  output logic                fault_o,
  output logic [63:0]         real_addr_o,
  output logic [1:0]          prot_o
);
  localparam int IW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [1:0] ACC_WRITE = 2'b10;

  logic [PAIRS-1:0] vld_q;
  logic             prob_q;
  logic [63:0]      mask_q [PAIRS];
  logic [63:0]      bepi_q [PAIRS];
  logic [63:0]      brpn_q [PAIRS];
  logic [1:0]       pp_q   [PAIRS];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_q  <= '0;
      prob_q <= 1'b0;
    end else if (sync_i) begin
      prob_q <= problem_i;
      for (int i = 0; i < PAIRS; i++) begin
        vld_q[i]  <= problem_i ? upper_i[i*64] : upper_i[i*64+1];
        mask_q[i] <= {36'd0, upper_i[i*64+2 +: 11], 17'h1FFFF};
        bepi_q[i] <= {upper_i[i*64+17 +: 47], 17'd0};
        brpn_q[i] <= {lower_i[i*64+17 +: 47], 17'd0};
        pp_q[i]   <= lower_i[i*64 +: 2];
      end
    end
  end

  logic [PAIRS-1:0] match;
  for (genvar g = 0; g < PAIRS; g++) begin : g_cmp
    assign match[g] = vld_q[g] && ((ea_i & ~mask_q[g]) == (bepi_q[g] & ~mask_q[g]));
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = PAIRS - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  wire found = |match;
  wire deny  = (pp_q[sel] == 2'b00 && prob_q) || (acc_i == ACC_WRITE && pp_q[sel][0]);

  assign hit_o       = found && !deny;
  assign fault_o     = found && deny;
  assign prot_o      = found ? pp_q[sel] : 2'b00;
  assign real_addr_o = found ? (brpn_q[sel] | (ea_i & mask_q[sel])) : 64'd0;

  p_excl_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hit_o && fault_o));

  p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !(hit_o || fault_o) |-> (real_addr_o == 64'd0 && prot_o == 2'b00));

  p_offset_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o || fault_o) |-> (real_addr_o[16:0] == ea_i[16:0]));

  p_write_ok_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && acc_i == ACC_WRITE) |-> (prot_o == 2'b10 || (prot_o == 2'b00 && !prob_q)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sync_i ##1 ($stable(ea_i) && $stable(acc_i))) |->
      ($stable(hit_o) && $stable(fault_o) && $stable(real_addr_o) && $stable(prot_o)));
endmodule

// File: tb/bat_block_matcher_test.sv
module bat_block_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 0, rst = 1, sync = 0, prob = 0;
  logic [NP*64-1:0] upper_bus, lower_bus;
  logic [63:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        hit, fault;
  logic [63:0] ra;
  logic [1:0]  pp;

  logic [63:0] up [NP];
  logic [63:0] lo [NP];
  logic [63:0] m_up [NP];
  logic [63:0] m_lo [NP];
  logic        m_prob;
  logic        m_empty;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) begin
      upper_bus[i*64 +: 64] = up[i];
      lower_bus[i*64 +: 64] = lo[i];
    end

  bat_block_matcher #(.PAIRS(NP)) uut (
    .clk_i(clk), .rst_i(rst), .sync_i(sync), .problem_i(prob),
    .upper_i(upper_bus), .lower_i(lower_bus), .ea_i(ea), .acc_i(acc),
    .hit_o(hit), .fault_o(fault), .real_addr_o(ra), .prot_o(pp));

  function automatic logic [63:0] mk_up(logic [63:0] base, logic [10:0] bl, logic vs, logic vp);
    return (base & ~64'h1FFFF) | (64'(bl) << 2) | (64'(vs) << 1) | 64'(vp);
  endfunction

  function automatic logic [63:0] mk_lo(logic [63:0] rpn, logic [1:0] p);
    return (rpn & ~64'h1FFFF) | 64'(p);
  endfunction

  task automatic expect_out(input logic [63:0] a, input logic [1:0] t,
                            output logic eh, output logic ef, output logic [63:0] er, output logic [1:0] ep);
    eh = 0; ef = 0; er = '0; ep = '0;
    if (!m_empty)
      for (int i = 0; i < NP; i++) begin
        logic act;
        logic [63:0] msk;
        act = m_prob ? m_up[i][0] : m_up[i][1];
        msk = (64'(m_up[i][12:2]) << 17) | 64'h1FFFF;
        if (act && ((a & ~msk) == ({m_up[i][63:17], 17'd0} & ~msk))) begin
          logic d;
          ep = m_lo[i][1:0];
          er = {m_lo[i][63:17], 17'd0} | (a & msk);
          d  = (ep == 2'b00 && m_prob) || (t == 2'b10 && (ep == 2'b01 || ep == 2'b11));
          eh = !d; ef = d;
          break;
        end
      end
  endtask

  task automatic probe(input logic [63:0] a, input logic [1:0] t, input string tag);
    logic eh, ef;
    logic [63:0] er;
    logic [1:0] ep;
    @(negedge clk);
    ea = a; acc = t;
    #1;
    expect_out(a, t, eh, ef, er, ep);
    checks++;
    if (hit !== eh || fault !== ef || ra !== er || pp !== ep) begin
      failures++;
      $display("FAIL %s ea=%h acc=%0d actual hit=%b fault=%b ra=%h prot=%b expected hit=%b fault=%b ra=%h prot=%b",
               tag, a, t, hit, fault, ra, pp, eh, ef, er, ep);
    end
  endtask

  task automatic do_sync(input logic mode);
    @(negedge clk);
    sync = 1; prob = mode;
    ea = m_empty ? 64'h0 : {m_up[0][63:17], 17'd5}; acc = 2'b01;
    #1;
    begin
      logic eh, ef;
      logic [63:0] er;
      logic [1:0] ep;
      expect_out(ea, acc, eh, ef, er, ep);
      checks++;
      if (hit !== eh || ra !== er) begin
        failures++;
        $display("FAIL R2 strobe-cycle lookup actual hit=%b ra=%h expected hit=%b ra=%h", hit, ra, eh, er);
      end
    end
    @(posedge clk);
    for (int i = 0; i < NP; i++) begin m_up[i] = up[i]; m_lo[i] = lo[i]; end
    m_prob = mode; m_empty = 0;
    @(negedge clk);
    sync = 0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NP; i++) begin
      logic [63:0] b, msk;
      b   = {up[i][63:17], 17'd0};
      msk = (64'(up[i][12:2]) << 17) | 64'h1FFFF;
      for (int t = 0; t < 3; t++) begin
        probe(b, 2'(t), tag);
        probe(b | msk, 2'(t), tag);
        probe((b | msk) + 64'd1, 2'(t), tag);
        probe(b - 64'd1, 2'(t), tag);
      end
      for (int k = 0; k < 64; k++) probe(b ^ (64'd1 << k), 2'(k % 3), tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin up[i] = '0; lo[i] = '0; m_up[i] = '0; m_lo[i] = '0; end
    m_prob = 0; m_empty = 1;
    up[0] = mk_up(64'h0000_0123_1000_0000, 11'h000, 1, 0);
    lo[0] = mk_lo(64'h0000_0000_8000_0000, 2'b10);
    up[1] = mk_up(64'h0000_0000_2000_0000, 11'h007, 0, 1);
    lo[1] = mk_lo(64'h0000_0007_0000_0000, 2'b01);
    up[2] = mk_up(64'h0000_0000_4000_0000, 11'h7FF, 1, 1);
    lo[2] = mk_lo(64'h0000_0000_F000_0000, 2'b10);
    up[3] = mk_up(64'h0000_0000_4000_0000, 11'h000, 1, 1);
    lo[3] = mk_lo(64'h0000_0000_0AA0_0000, 2'b11);
    repeat (3) @(posedge clk);
    // R1: empty table after reset
    probe(64'h0000_0000_4000_0000, 2'b01, "R1");
    probe(64'h0000_0123_1000_0000, 2'b00, "R1");
    @(negedge clk); rst = 0;
    probe(64'h0000_0000_4000_0000, 2'b10, "R1");
    probe(64'h0000_0000_2000_0000, 2'b01, "R1");
    // R2/R3/R4/R5/R6/R7 in supervisor then problem state
    do_sync(0);
    sweep("R3/R4/R5/R6/R7 supervisor");
    do_sync(1);
    sweep("R3/R4/R5/R6/R7 problem");
    // R11: raw changes without a strobe are ignored
    @(negedge clk);
    up[1] = mk_up(64'h0000_0000_2000_0000, 11'h007, 0, 0);
    lo[2] = mk_lo(64'h0, 2'b01);
    prob = 0;
    probe(64'h0000_0000_2001_2345, 2'b01, "R11");
    probe(64'h0000_0000_4567_8000, 2'b10, "R11");
    // R8/R9: every protection code in both modes and every access type
    for (int mode = 0; mode < 2; mode++)
      for (int p = 0; p < 4; p++) begin
        up[2] = mk_up(64'h0000_0000_4000_0000, 11'h7FF, 1, 1);
        lo[2] = mk_lo(64'h0000_0000_F000_0000, 2'(p));
        do_sync(mode[0]);
        for (int t = 0; t < 4; t++) probe(64'h0000_0000_4ABC_DEF0, 2'(t), "R8/R9/R10");
      end
    // R6: lowest index wins when the small block is fully inside a larger one
    up[0] = mk_up(64'h0000_0000_4000_0000, 11'h000, 1, 1);
    lo[0] = mk_lo(64'h0000_0000_1230_0000, 2'b10);
    do_sync(0);
    probe(64'h0000_0000_4001_0000, 2'b01, "R6");
    probe(64'h0000_0000_4002_0000, 2'b01, "R6");
    // R10: all inactive
    for (int i = 0; i < NP; i++) up[i] = up[i] & ~64'h3;
    do_sync(1);
    probe(64'h0000_0000_4000_0000, 2'b01, "R10");
    probe(64'h0000_0000_2000_0000, 2'b10, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule